// File: doc/BRIEF.md
# UART Interrupt Identification and Priority

This block is the interrupt front end of a 16550-style serial port. It holds the 4-bit interrupt enable register and the transmit-empty pending flag. Every cycle it takes the enabled interrupt sources, picks the single highest-priority one, and registers two outputs: an identification byte and a level interrupt line. The receive path, the transmit shifter, the FIFO storage and the baud timing are outside this block. Their state arrives on plain inputs: line status flags, receive FIFO fill level and trigger selection, the FIFO-enable state, a character-timeout pending flag, and the modem delta bits.

Register accesses reach the block as single-cycle strobes:
- an enable-register write with its data byte;
- a read of the identification byte, whose value is the current `iir_q`;
- a write of the transmit holding register.

The block applies the side effects of each access to the transmit-empty pending flag. It also sets that flag when the transmit-empty status rises. The block moves no data stream, so it has no valid/ready interface. All pins are plain control and status, sampled on every rising clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `iir_q` is 0x01, `irq` is 0, `ier_q` is 0 and the transmit-empty pending flag is clear.
- R2: Bits 3:0 of `iir_q` carry the cause code: 0x6 line error, 0xC character timeout, 0x4 received data, 0x2 transmit empty, 0x0 modem change, and 0x1 when nothing is pending. Bits 5:4 are 0.
- R3: When several sources are active, the reported cause follows this order, highest first: line error, character timeout, received data, transmit empty, modem change.
- R4: The line error source is active when `ier_q[2]` is 1 and any of `lsr_in[4:1]` (overrun, parity, framing, break) is 1.
- R5: The character timeout source is active when `tmo_pend` is 1 and `ier_q[0]` (the received-data enable) is 1. It has no enable of its own.
- R6: The received data source needs `ier_q[0]` and `lsr_in[0]` (data ready). With `fifo_en` = 1 it also needs `rx_level` at or above a trigger value. `trig_sel` 0, 1, 2 and 3 select 1, FIFO_DEPTH/4, FIFO_DEPTH/2 and FIFO_DEPTH-2 (1, 4, 8 and 14 at depth 16). With `fifo_en` = 0 the level is ignored.
- R7: `iir_q[7:6]` reads 2'b11 while `fifo_en` is 1 and 2'b00 otherwise.
- R8: A pulse on `iir_rd` while `iir_q[3:0]` is 0x2 clears the transmit-empty pending flag. A pulse on `iir_rd` while any other code shows leaves the flag unchanged.
- R9: An `ier_wr` sets the pending flag when `ier_wdata[1]` is 1 and `lsr_in[5]` (transmit holding empty) is 1, whether or not a read cleared it earlier. Otherwise it clears the flag.
- R10: `ier_wr` stores `ier_wdata[3:0]` into `ier_q`. Bits 7:4 of the data are dropped. Bit 0 enables received data, bit 1 transmit empty, bit 2 line error, bit 3 modem change.
- R11: A pulse on `thr_wr` clears the transmit-empty pending flag.
- R12: A 0-to-1 transition of `lsr_in[5]` sets the pending flag. When accesses collide, an enable write takes precedence over a holding write, which takes precedence over an identification read, which takes precedence over the rising edge.
- R13: `irq` is 1 exactly when `iir_q[3:0]` differs from 0x1. Both outputs are registered and show a source change on the first rising edge after it.
- R14: The modem change source is active when `ier_q[3]` is 1 and any bit of `modem_delta` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| rx_level | input | LVL_W | Receive FIFO fill count |
| trig_sel | input | 2 | Receive trigger selection |
| lsr_in | input | 6 | Line status: 0 data ready, 1 overrun, 2 parity, 3 framing, 4 break, 5 holding empty |
| tmo_pend | input | 1 | Character timeout pending |
| modem_delta | input | 4 | Modem status change bits |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| iir_rd | input | 1 | Identification read strobe |
| thr_wr | input | 1 | Transmit holding write strobe |
| ier_q | output | 4 | Stored interrupt enables |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Level interrupt request |

## Verification
A change on a source input (line status, level, timeout, modem delta, FIFO enable) reaches `iir_q` and `irq` at the first rising edge after it. An access strobe acts in two stages: it updates `ier_q` and the pending flag at its own edge, and the identification byte follows one edge later. So a read or write needs two edges before its effect is visible on the identification byte.

The bench drives on falling edges and counts exactly those edges before sampling on a falling edge. It also samples once before the edge, to confirm the old value is still held. The sweep covers all 16 enable values against 32 combinations of the sources and both FIFO modes. Each case has a rotated level and trigger selection, and the expected byte is computed from the priority rules.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;

  localparam logic [3:0] ID_MODEM   = 4'h0;
  localparam logic [3:0] ID_NONE    = 4'h1;
  localparam logic [3:0] ID_THRE    = 4'h2;
  localparam logic [3:0] ID_RXDATA  = 4'h4;
  localparam logic [3:0] ID_LINE    = 4'h6;
  localparam logic [3:0] ID_TIMEOUT = 4'hC;

  // source slots, index 0 is the highest priority
  localparam int SRC_LINE    = 0;
  localparam int SRC_TIMEOUT = 1;
  localparam int SRC_RXDATA  = 2;
  localparam int SRC_THRE    = 3;
  localparam int SRC_MODEM   = 4;

  // enable register bit positions
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  function automatic logic [3:0] id_of(input int idx);
    case (idx)
      SRC_LINE:    return ID_LINE;
      SRC_TIMEOUT: return ID_TIMEOUT;
      SRC_RXDATA:  return ID_RXDATA;
      SRC_THRE:    return ID_THRE;
      default:     return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg #(
  parameter int EN_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ier_wr,
  input  logic [7:0]      ier_wdata,
  input  logic            thr_wr,
  input  logic            iir_rd_thre,
  input  logic            thre_now,
  output logic [EN_W-1:0] ier_q,
  output logic            thr_pend_q
);
  import uart_irq_pkg::*;

  logic thre_prev_q;
  logic thre_rise;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^ier_wdata[7:EN_W];
  assign thre_rise = thre_now & ~thre_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q       <= '0;
      thre_prev_q <= 1'b1;
    end else begin
      thre_prev_q <= thre_now;
      if (ier_wr) ier_q <= ier_wdata[EN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_pend_q <= 1'b0;
    end else if (ier_wr) begin
      thr_pend_q <= ier_wdata[EN_THRE] & thre_now;
    end else if (thr_wr) begin
      thr_pend_q <= 1'b0;
    end else if (iir_rd_thre) begin
      thr_pend_q <= 1'b0;
    end else if (thre_rise) begin
      thr_pend_q <= 1'b1;
    end
  end

  // R10
  ier_low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier_q == $past(ier_wdata[EN_W-1:0]));

  // R9
  ier_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && ier_wdata[EN_THRE] && thre_now) |=> thr_pend_q);

  // R9
  ier_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && !ier_wdata[EN_THRE]) |=> !thr_pend_q);

  // R11
  thr_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !ier_wr) |=> !thr_pend_q);

  // R8
  iir_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd_thre && !ier_wr) |=> !thr_pend_q);
endmodule

// File: rtl/uart_irq_rx_trigger.sv
module uart_irq_rx_trigger #(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             fifo_en,
  input  logic             data_ready,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [1:0]       trig_sel,
  output logic             rx_req
);
  localparam int NUM_TRIG = 4;

  logic [LVL_W-1:0] thresh [NUM_TRIG];
  logic [LVL_W-1:0] sel_thresh;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_thr
    localparam int TV = (i == 0) ? 1 :
                        (i == 1) ? FIFO_DEPTH / 4 :
                        (i == 2) ? FIFO_DEPTH / 2 : FIFO_DEPTH - 2;
    assign thresh[i] = LVL_W'(TV);
  end

  assign sel_thresh = thresh[trig_sel];

  always_comb begin
    if (!data_ready)   rx_req = 1'b0;
    else if (!fifo_en) rx_req = 1'b1;
    else               rx_req = (rx_level >= sel_thresh);
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int N = uart_irq_pkg::NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [3:0]   code,
  output logic         any
);
  import uart_irq_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_grant
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_low
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign any = |req;

  always_comb begin
    code = ID_NONE;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = id_of(i);
    end
  end

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [1:0]       trig_sel,
  input  logic [5:0]       lsr_in,
  input  logic             tmo_pend,
  input  logic [3:0]       modem_delta,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             iir_rd,
  input  logic             thr_wr,
  output logic [3:0]       ier_q,
  output logic [7:0]       iir_q,
  output logic             irq
);
  import uart_irq_pkg::*;

  localparam int EN_W = 4;

  logic               thr_pend;
  logic               iir_rd_thre;
  logic               rx_req;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic [3:0]         code;
  logic               any_req;

  assign iir_rd_thre = iir_rd & (iir_q[3:0] == ID_THRE);

  uart_irq_enable_reg #(.EN_W(EN_W)) u_en (
    .clk         (clk),
    .rst_n       (rst_n),
    .ier_wr      (ier_wr),
    .ier_wdata   (ier_wdata),
    .thr_wr      (thr_wr),
    .iir_rd_thre (iir_rd_thre),
    .thre_now    (lsr_in[5]),
    .ier_q       (ier_q),
    .thr_pend_q  (thr_pend)
  );

  uart_irq_rx_trigger #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_trig (
    .fifo_en    (fifo_en),
    .data_ready (lsr_in[0]),
    .rx_level   (rx_level),
    .trig_sel   (trig_sel),
    .rx_req     (rx_req)
  );

  always_comb begin
    req              = '0;
    req[SRC_LINE]    = ier_q[EN_LINE] & (|lsr_in[4:1]);
    req[SRC_TIMEOUT] = ier_q[EN_RX] & tmo_pend;
    req[SRC_RXDATA]  = ier_q[EN_RX] & rx_req;
    req[SRC_THRE]    = ier_q[EN_THRE] & thr_pend;
    req[SRC_MODEM]   = ier_q[EN_MODEM] & (|modem_delta);
  end

  uart_irq_prio #(.N(NUM_SRC)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant),
    .code  (code),
    .any   (any_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iir_q <= {4'h0, ID_NONE};
      irq   <= 1'b0;
    end else begin
      iir_q <= {fifo_en, fifo_en, 2'b00, code};
      irq   <= any_req;
    end
  end

  // R13
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir_q[3:0] != ID_NONE));

  // R4
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[EN_LINE] && (|lsr_in[4:1])) |=> iir_q[3:0] == ID_LINE);

  // R5
  timeout_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_q[EN_RX] |=> iir_q[3:0] != ID_TIMEOUT);

  // R7
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> iir_q[7:6] == {2{$past(fifo_en)}});
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fifo_en;
  logic [LW-1:0] rx_level;
  logic [1:0]    trig_sel;
  logic [5:0]    lsr_in;
  logic          tmo_pend;
  logic [3:0]    modem_delta;
  logic          ier_wr;
  logic [7:0]    ier_wdata;
  logic          iir_rd;
  logic          thr_wr;
  logic [3:0]    ier_q;
  logic [7:0]    iir_q;
  logic          irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  uart_irq_ident #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_level(rx_level),
    .trig_sel(trig_sel), .lsr_in(lsr_in), .tmo_pend(tmo_pend),
    .modem_delta(modem_delta), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .ier_q(ier_q), .iir_q(iir_q), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_ier(input logic [7:0] v);
    ier_wr = 1'b1; ier_wdata = v;
    step();
    ier_wr = 1'b0;
  endtask

  function automatic logic [7:0] exp_iir(input logic [3:0] ie, input logic [5:0] lsr,
      input logic tmo, input logic [3:0] md, input logic fe, input int lvl,
      input int ts, input logic pend);
    int thr;
    logic [3:0] c;
    thr = (ts == 0) ? 1 : (ts == 1) ? DEPTH / 4 : (ts == 2) ? DEPTH / 2 : DEPTH - 2;
    if (ie[2] && (|lsr[4:1]))                    c = 4'h6;
    else if (ie[0] && tmo)                       c = 4'hC;
    else if (ie[0] && lsr[0] && (!fe || lvl >= thr)) c = 4'h4;
    else if (ie[1] && pend)                      c = 4'h2;
    else if (ie[3] && (|md))                     c = 4'h0;
    else                                         c = 4'h1;
    return {fe, fe, 2'b00, c};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 8'h0, 8'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; rx_level = '0; trig_sel = 2'd0;
    lsr_in = 6'h20; tmo_pend = 1'b0; modem_delta = 4'h0;
    ier_wr = 1'b0; ier_wdata = 8'h00; iir_rd = 1'b0; thr_wr = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state
    check("R1 iir", iir_q, 8'h01);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 ier", {4'd0, ier_q}, 8'h00);
    step();
    write_ier(8'h02);
    step();
    // R1: pending flag clear after reset means no holding-empty cause without a rearm... the write rearms
    check("R9 rearm after reset", iir_q, 8'h02);
    write_ier(8'h00);
    step();

    // R4 / R13 latency
    write_ier(8'h04);
    step();
    lsr_in = 6'h28;
    check("R13 irq held before edge", {7'd0, irq}, 8'h00);
    step();
    check("R4 line code", iir_q, 8'h06);
    check("R13 irq high", {7'd0, irq}, 8'h01);
    lsr_in = 6'h20;
    step();
    check("R13 irq low", {7'd0, irq}, 8'h00);

    // R8 read clears holding-empty
    write_ier(8'h02);
    step();
    check("R9 armed", iir_q, 8'h02);
    iir_rd = 1'b1; step(); iir_rd = 1'b0;
    step();
    check("R8 read clears", iir_q, 8'h01);
    // R9 rearm after read
    write_ier(8'h02);
    step();
    check("R9 rearm after read", iir_q, 8'h02);
    // R11 holding write clears
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    step();
    check("R11 thr write clears", iir_q, 8'h01);
    // R9 write with holding not empty does not arm
    lsr_in = 6'h00;
    step();
    write_ier(8'h02);
    step();
    check("R9 no arm when busy", iir_q, 8'h01);
    // R12 rising edge arms
    lsr_in = 6'h20;
    step();
    step();
    check("R12 rise arms", iir_q, 8'h02);
    // R8 read under another code leaves flag
    write_ier(8'h03);
    lsr_in = 6'h21;
    step();
    check("R3 rx over thre", iir_q, 8'h04);
    iir_rd = 1'b1; step(); iir_rd = 1'b0;
    lsr_in = 6'h20;
    step();
    check("R8 other code keeps flag", iir_q, 8'h02);
    // R10 high bits dropped
    write_ier(8'hF5);
    check("R10 low nibble", {4'd0, ier_q}, 8'h05);
    // R7 fifo bits
    write_ier(8'h00);
    fifo_en = 1'b1;
    step();
    check("R7 fifo on", iir_q, 8'hC1);
    fifo_en = 1'b0;
    step();
    check("R7 fifo off", iir_q, 8'h01);

    // sweep: R2 R3 R5 R6 R14 R7
    begin
      int it = 0;
      for (int fe = 0; fe < 2; fe++) begin
        for (int ie = 0; ie < 16; ie++) begin
          for (int s = 0; s < 32; s++) begin
            logic [5:0] l;
            logic [3:0] md;
            logic       pend;
            logic [7:0] e;
            int         lvl;
            int         ts;
            lvl = (it * 7) % (DEPTH + 1);
            ts  = it % 4;
            md  = s[3] ? (4'h1 << (it % 4)) : 4'h0;
            l   = 6'h00;
            l[0] = s[2];
            if (s[0]) l[1 + (it % 4)] = 1'b1;
            l[5] = s[4];
            fifo_en = fe[0]; rx_level = LW'(lvl); trig_sel = 2'(ts);
            tmo_pend = s[1]; modem_delta = md; lsr_in = l;
            step();
            write_ier({4'(it), 4'(ie)});
            step();
            pend = ie[1] & s[4];
            e = exp_iir(4'(ie), l, s[1], md, fe[0], lvl, ts, pend);
            check("R2 R3 R5 R6 R14 sweep code", iir_q, e);
            check("R13 sweep irq", {7'd0, irq}, {7'd0, e[3:0] != 4'h1});
            it++;
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule